// File: doc/BRIEF.md
# Paged Address Translator with Protection

The block turns a 28-bit byte virtual address into a 26-bit physical address using a single-level page table kept in physical memory. Pages are 8 KB, so the low 13 bits pass through unchanged. The upper 15 bits select one of 32768 table entries. Each entry names one of 8192 frames. It also carries a valid bit, a reference bit and a protection code that ranks the none, read and write rights across four privilege levels.

A requester presents the address, a read/write flag and its current privilege. The block fetches the entry over a one-outstanding memory port and checks it. On a successful access whose reference bit is still clear, the block writes the entry back with that bit set. It then reports either a physical address or a fault code.

Top module: `page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: The entry is read (`mem_we`=0) at address `pt_base + 4*va[27:13]`, and that address is word-aligned (`mem_addr[1:0]`=0).
- R3: An entry with bit 31 (valid) clear yields `fault_code`=01 (page fault) and causes no memory write.
- R4: Privilege is coded kernel=0, executive=1, supervisor=2, user=3, where a lower value means more privilege. Entry bits [29:28] give the least privileged level that may write, and bits [27:26] give the least privileged level that may read. A read is allowed when `priv <= read level` or `priv <= write level`. A write is allowed when `priv <= write level`. A denied access yields `fault_code`=10 and causes no memory write.
- R5: A page fault takes priority over an access fault.
- R6: A permitted access yields `fault_code`=00 and `pa = {entry[12:0], va[12:0]}`.
- R7: When the access is permitted and entry bit 30 (reference) is clear, exactly one write of the entry with bit 30 set goes to the same address, and `done` comes only after that write is acknowledged.
- R8: When the access is permitted and bit 30 is already set, no write occurs.
- R9: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ready` accepts them, and memory may take any number of cycles to accept and to respond.
- R10: Once a request is accepted, `req_ready` stays low until its `done`.
- R11: `done` is a single-cycle pulse per translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 26 | Physical base address of the page table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 28 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 2 | Current privilege (0 kernel .. 3 user) |
| done | output | 1 | Result valid for one cycle |
| fault_code | output | 2 | 00 ok, 01 page fault, 10 access fault |
| pa | output | 26 | Physical address when fault_code is 00 |
| mem_req | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory accepts command |
| mem_we | output | 1 | 1 = write command |
| mem_addr | output | 26 | Memory word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data or write acknowledge |
| mem_rdata | input | 32 | Read data |

## Verification
The bench targets entries whose reference bit is clear. A design that skipped the write-back would leave the bit unset, and a design that wrote back on faults or on already-referenced pages would show extra memory writes. It runs every privilege against both read and write, including pages where reading is granted only through the write limit. A design that did not let the write right imply a read right would raise false access faults there. An invalid entry whose protection also denies the access must report a page fault, which catches inverted fault priority. The extreme page numbers and offsets expose a truncated entry address or a misjoined physical address, and random memory latency on both the command and the response exposes a design that drops its command before acceptance.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VAW = 28,
  parameter int PAW = 26,
  parameter int OFFW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PAW-1:0] pt_base,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [VAW-1:0] req_va,
  input  logic           req_write,
  input  logic [1:0]     req_priv,
  output logic           done,
  output logic [1:0]     fault_code,
  output logic [PAW-1:0] pa,
  output logic           mem_req,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [PAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_rvalid,
  input  logic [31:0]    mem_rdata
);
  localparam int VPNW = VAW - OFFW;
  localparam int PFNW = PAW - OFFW;

  typedef enum logic [2:0] {S_IDLE, S_RDREQ, S_RDWAIT, S_WRREQ, S_WRWAIT, S_RESP} state_t;
  state_t state;

  logic [VAW-1:0] va_q;
  logic           wr_q;
  logic [1:0]     priv_q;
  logic [31:0]    pte_q;
  logic [1:0]     code_q;

  logic [1:0] rlim, wlim;
  logic       valid_bit, allowed;
  assign valid_bit = mem_rdata[31];
  assign wlim      = mem_rdata[29:28];
  assign rlim      = mem_rdata[27:26];
  assign allowed   = wr_q ? (priv_q <= wlim) : (priv_q <= rlim || priv_q <= wlim);

  assign req_ready  = state == S_IDLE;
  assign done       = state == S_RESP;
  assign fault_code = code_q;
  assign pa         = {pte_q[PFNW-1:0], va_q[OFFW-1:0]};
  assign mem_req    = state == S_RDREQ || state == S_WRREQ;
  assign mem_we     = state == S_WRREQ;
  assign mem_addr   = pt_base + PAW'({va_q[VAW-1:OFFW], 2'b00});
  assign mem_wdata  = pte_q | 32'h4000_0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      priv_q <= '0;
      pte_q  <= '0;
      code_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          priv_q <= req_priv;
          state  <= S_RDREQ;
        end
        S_RDREQ: if (mem_ready) state <= S_RDWAIT;
        S_RDWAIT: if (mem_rvalid) begin
          pte_q <= mem_rdata;
          if (!valid_bit) begin
            code_q <= 2'b01;
            state  <= S_RESP;
          end else if (!allowed) begin
            code_q <= 2'b10;
            state  <= S_RESP;
          end else begin
            code_q <= 2'b00;
            state  <= mem_rdata[30] ? S_RESP : S_WRREQ;
          end
        end
        S_WRREQ: if (mem_ready) state <= S_WRWAIT;
        S_WRWAIT: if (mem_rvalid) state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [27:0] req_va,
  input logic        done,
  input logic [1:0]  fault_code,
  input logic [25:0] pa,
  input logic        mem_req,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [25:0] mem_addr,
  input logic [31:0] mem_wdata
);
  logic [12:0] off_q;
  always_ff @(posedge clk)
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_va[12:0];

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_refset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[30]);
  p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code == 2'b00) |-> pa[12:0] == off_q);
  p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault_code != 2'b11);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind page_xlate page_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .done(done), .fault_code(fault_code), .pa(pa),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [25:0] pt_base = 26'h010_0000;
  logic req_valid = 0, req_write = 0, mem_ready = 0, mem_rvalid = 0;
  logic [27:0] req_va = 0;
  logic [1:0] req_priv = 0;
  logic [31:0] mem_rdata = 0;
  logic req_ready, done, mem_req, mem_we;
  logic [1:0] fault_code;
  logic [25:0] pa, mem_addr;
  logic [31:0] mem_wdata;

  page_xlate u_dut (.*);

  int checks = 0, errors = 0, writes = 0, cycles = 0;
  logic [31:0] mem [int];
  logic [1:0]  q_code[$];
  logic [25:0] q_pa[$];
  int          q_wr[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model with random latency
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      int a; logic w; logic [31:0] d;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      a = int'(mem_addr); w = mem_we; d = mem_wdata;
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
      if (w) begin
        chk(d == (rd(a) | 32'h4000_0000), "R7 wdata", d, rd(a) | 32'h4000_0000);
        mem[a] = d;
        writes++;
      end
      repeat ($urandom_range(0, 3)) @(negedge clk);
      mem_rdata = rd(a);
      mem_rvalid = 1;
      @(negedge clk);
      mem_rvalid = 0;
    end
  end

  // monitor / scoreboard
  int wr_base = 0;
  always @(negedge clk) if (done) begin
    if (q_code.size() == 0) chk(0, "R11 unexpected done", 1, 0);
    else begin
      logic [1:0] ec; logic [25:0] ep; int ew;
      ec = q_code.pop_front(); ep = q_pa.pop_front(); ew = q_wr.pop_front();
      chk(fault_code == ec, ec == 1 ? "R3/R5 code" : (ec == 2 ? "R4 code" : "R6 code"), 32'(fault_code), 32'(ec));
      if (ec == 0) chk(pa == ep, "R6 pa", 32'(pa), 32'(ep));
      chk(writes - wr_base == ew, ew ? "R7 writeback" : "R8 no write", 32'(writes - wr_base), 32'(ew));
    end
  end

  task automatic xlate(logic [27:0] va, logic wr, logic [1:0] pr);
    logic [31:0] e; logic [1:0] ec; bit ok;
    e = rd(int'(pt_base + 26'({va[27:13], 2'b00})));
    ok = wr ? (pr <= e[29:28]) : (pr <= e[27:26] || pr <= e[29:28]);
    ec = !e[31] ? 2'd1 : (!ok ? 2'd2 : 2'd0);
    q_code.push_back(ec);
    q_pa.push_back({e[12:0], va[12:0]});
    q_wr.push_back((ec == 0 && !e[30]) ? 1 : 0);
    while (!req_ready) @(negedge clk);
    wr_base = writes;
    req_va = va; req_write = wr; req_priv = pr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy", 32'(req_ready), 0);
    while (q_code.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!done, "R11 pulse", 32'(done), 0);
  endtask

  function automatic int ea(int vpn);
    return int'(pt_base) + vpn * 4;
  endfunction

  initial begin
    // entry: [31] valid [30] ref [29:28] write lim [27:26] read lim [12:0] frame
    mem[ea(5)]      = 32'h8000_0000 | (32'd1 << 28) | (32'd3 << 26) | 32'h0123;
    mem[ea(7)]      = 32'h0000_0055;
    mem[ea(9)]      = 32'hC000_0000 | (32'd2 << 28) | 32'h0ABC;
    mem[ea(32767)]  = 32'hC000_1FFF;
    mem[ea(0)]      = 32'h8000_0000 | (32'd3 << 28) | 32'h0001;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !mem_req, "R1 reset", {req_ready, done, mem_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    xlate({15'd5, 13'h0042}, 0, 3);             // R6 R7 user read, ref clear
    chk(mem[ea(5)][30], "R7 ref bit set", mem[ea(5)], mem[ea(5)] | 32'h4000_0000);
    xlate({15'd5, 13'h1000}, 0, 3);             // R8 ref already set
    xlate({15'd5, 13'h0004}, 1, 3);             // R4 user write denied
    xlate({15'd5, 13'h0008}, 1, 1);             // R4 executive write ok
    xlate({15'd7, 13'h0000}, 1, 3);             // R5 invalid and denied -> page fault
    xlate({15'd7, 13'h0010}, 0, 0);             // R3 invalid
    xlate({15'd9, 13'h0020}, 0, 2);             // R4 read via write right
    xlate({15'd9, 13'h0020}, 0, 3);             // R4 user read denied
    xlate({15'd32767, 13'h1FFF}, 1, 0);         // R2 R6 max page/offset
    xlate({15'd32767, 13'h0000}, 0, 2);         // R4 denied
    xlate({15'd0, 13'h0ABC}, 1, 3);             // R2 page zero, R7 writeback
    xlate({15'd12345, 13'h0000}, 0, 0);         // R3 unmapped
    for (int v = 0; v < 4; v++)
      for (int w = 0; w < 2; w++) xlate({15'd9, 13'(v * 7)}, w[0], 2'(v)); // R4 R9 sweep
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule